// File: doc/BRIEF.md
# Dual-Ratio Programmable Clock Divider

This block sits in the fast source clock domain and turns that clock into two rate enables: one for the core and one for the peripheral (system) side. A single control register sets both ratios. The core ratio is a power of two chosen by a 2-bit log2 code. The system ratio is any integer from 1 to 15 chosen by a 4-bit code. Each output is a one-cycle enable pulse in the source domain, not a gated clock. A ratio of 1 keeps the enable high all the time.

Software writes the register through a one-word write port and can read it back at any time. The register also exposes a read-only multiplier field, which holds its default of 10. Ratios can be changed while the block is running.

A written ratio is not applied at once. Both paths adopt their new ratios together, at a cycle where both of them end a period at the same time. This avoids shortened pulses and keeps the core and system pulse trains in a fixed phase relation. A system code of zero is illegal. It is dropped and raises a sticky error flag.

Top module: `dual_rate_divider`

## Requirements
- R1: After reset, rdata reads 0x004A: multiplier 10 in bits [5:0], system code 0001 in bits [9:6], core code 00 in bits [11:10], error flag (bit 15) clear, and bits [14:12] zero. Both enables are high.
- R2: Core code in bits [11:10] selects the core ratio: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8. Once that ratio is in force, core_en is high in exactly one cycle of every ratio cycles.
- R3: System code N (1 to 15) in bits [9:6] makes sys_en high in exactly one cycle of every N cycles once that ratio is in force.
- R4: An enable whose ratio in force is 1 is high in every cycle.
- R5: A write whose system code is 0000 leaves the system ratio unchanged, still applies the core code carried in the same write, and sets error bit 15. That bit stays set until reset.
- R6: Bits [5:0] always read 10. Writes do not change them.
- R7: Pending ratios are adopted only at the edge closing a cycle in which both paths are in the last cycle of their periods. Until then both outputs keep their previous pulse spacing, and no period is cut short.
- R8: After each adoption both enables pulse in the same cycle. When one ratio divides the other, every pulse of the slower enable coincides with a pulse of the faster one.
- R9: The cycle after a write, rdata shows the written core code and the written system code (when nonzero).

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Control register read value |
| core_en | output | 1 | Core rate enable pulse |
| sys_en | output | 1 | System rate enable pulse |

## Verification
The bench goes after the code 0000 write. A design that loaded it would stall sys_en or divide by 16. A design that skipped the whole write would lose the core code carried with it. A design that dropped the flag would leave bit 15 clear.

It also rewrites ratios in the middle of a period. A design that switched at once would emit a runt interval or lose the core/system phase lock. A cycle-level reference of the joint adoption point exposes both.

Every core code and every system code from 1 to 15 is run, so a wrong decode shows up as a wrong pulse spacing. Divisible pairs such as 2 and 6 are checked for coincident pulses. Ratio-1 runs are checked for an enable that never drops.

// File: rtl/drd_pkg.sv
package drd_pkg;
   // How a divider path turns its control code into a ratio
   typedef enum logic {
      ENC_INT  = 1'b0,   // ratio equals the code
      ENC_LOG2 = 1'b1    // ratio equals 2**code
   } ratio_enc_e;
endpackage

// File: rtl/drd_ctl_reg.sv
module drd_ctl_reg #(
   parameter int DW       = 16,
   parameter int SYS_W    = 4,
   parameter int CORE_W   = 2,
   parameter int MULT_W   = 6,
   parameter int MULT_RST = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   output logic [SYS_W-1:0]  sys_code,
   output logic [CORE_W-1:0] core_code
);
   localparam int MULT_LSB = 0;
   localparam int SYS_LSB  = MULT_LSB + MULT_W;
   localparam int CORE_LSB = SYS_LSB + SYS_W;
   localparam int TOP_USED = CORE_LSB + CORE_W;
   localparam int ERR_BIT  = DW - 1;

   generate
      if (TOP_USED >= ERR_BIT) begin : g_bad_layout
         $error("drd_ctl_reg: fields overlap the error bit");
      end
      if (MULT_RST < 1 || MULT_RST >= (1 << MULT_W)) begin : g_bad_mult
         $error("drd_ctl_reg: multiplier default out of range");
      end
   endgenerate

   logic [SYS_W-1:0]  sys_q;
   logic [CORE_W-1:0] core_q;
   logic              err_q;
   logic [SYS_W-1:0]  wr_sys;
   logic [CORE_W-1:0] wr_core;

   assign wr_sys  = wdata[SYS_LSB +: SYS_W];
   assign wr_core = wdata[CORE_LSB +: CORE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_q  <= SYS_W'(1);
         core_q <= '0;
         err_q  <= 1'b0;
      end else if (wr_en) begin
         core_q <= wr_core;
         if (wr_sys == '0) begin
            err_q <= 1'b1;
         end else begin
            sys_q <= wr_sys;
         end
      end
   end

   always_comb begin
      rdata                       = '0;
      rdata[MULT_LSB +: MULT_W]   = MULT_W'(MULT_RST);
      rdata[SYS_LSB +: SYS_W]     = sys_q;
      rdata[CORE_LSB +: CORE_W]   = core_q;
      rdata[ERR_BIT]              = err_q;
   end

   assign sys_code  = sys_q;
   assign core_code = core_q;

   logic unused_wbits;
   assign unused_wbits = ^{wdata[MULT_LSB +: MULT_W], wdata[DW-1:TOP_USED]};

   // R5: the held system code is never zero
   p_sys_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sys_q != '0) else $error("system code became zero");

   // R5: a zero system code in a write leaves the held code alone
   p_zero_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sys == '0) |=> $stable(sys_q)) else $error("zero code loaded");

   // R5: the error flag is sticky
   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q) else $error("error flag cleared");
endmodule

// File: rtl/drd_div_path.sv
module drd_div_path
   import drd_pkg::*;
#(
   parameter ratio_enc_e ENC    = ENC_INT,
   parameter int         CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   input  logic              load_i,
   output logic              last_o,
   output logic              en_o
);
   localparam int RATIO_W = (ENC == ENC_LOG2) ? (1 << CODE_W) : CODE_W;
   localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

   generate
      if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code_w
         $error("drd_div_path: CODE_W must be 1..4");
      end
   endgenerate

   logic [RATIO_W-1:0] ratio_dec;
   logic [RATIO_W-1:0] act_q;
   logic [RATIO_W-1:0] cnt_q;

   generate
      if (ENC == ENC_LOG2) begin : g_log2
         assign ratio_dec = ONE << code_i;
      end else begin : g_int
         assign ratio_dec = code_i;
      end
   endgenerate

   assign last_o = (cnt_q == act_q - ONE);
   assign en_o   = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= ONE;
      end else begin
         cnt_q <= last_o ? '0 : cnt_q + ONE;
         if (load_i) begin
            act_q <= ratio_dec;
         end
      end
   end

   // R7: the phase counter stays inside the ratio in force
   p_cnt_in_ratio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < act_q) else $error("phase counter beyond ratio");

   // R7: the ratio in force moves only on a load
   p_ratio_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(act_q)) else $error("ratio changed without load");

   // R4: ratio one keeps the enable high
   p_unit_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == ONE) |-> en_o) else $error("ratio one enable dropped");
endmodule

// File: rtl/dual_rate_divider.sv
module dual_rate_divider
   import drd_pkg::*;
#(
   parameter int DW       = 16,
   parameter int SYS_W    = 4,
   parameter int CORE_W   = 2,
   parameter int MULT_W   = 6,
   parameter int MULT_RST = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          core_en,
   output logic          sys_en
);
   logic [SYS_W-1:0]  sys_code;
   logic [CORE_W-1:0] core_code;
   logic              core_last;
   logic              sys_last;
   logic              commit;

   drd_ctl_reg #(
      .DW       (DW),
      .SYS_W    (SYS_W),
      .CORE_W   (CORE_W),
      .MULT_W   (MULT_W),
      .MULT_RST (MULT_RST)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wdata     (wdata),
      .rdata     (rdata),
      .sys_code  (sys_code),
      .core_code (core_code)
   );

   // both paths adopt pending ratios only when their periods end together
   assign commit = core_last & sys_last;

   drd_div_path #(
      .ENC    (ENC_LOG2),
      .CODE_W (CORE_W)
   ) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .code_i (core_code),
      .load_i (commit),
      .last_o (core_last),
      .en_o   (core_en)
   );

   drd_div_path #(
      .ENC    (ENC_INT),
      .CODE_W (SYS_W)
   ) u_sys (
      .clk    (clk),
      .rst_n  (rst_n),
      .code_i (sys_code),
      .load_i (commit),
      .last_o (sys_last),
      .en_o   (sys_en)
   );

   // R8: after a joint boundary both enables restart together
   p_joint_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (core_en && sys_en)) else $error("paths out of phase");
endmodule

// File: tb/dual_rate_divider_test.sv
`timescale 1ns/1ps
module dual_rate_divider_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        core_en;
   logic        sys_en;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dual_rate_divider uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .core_en(core_en), .sys_en(sys_en)
   );

   // reference of the required rate behaviour
   int mcc, mcs, mac, mas, mpc, mps;
   bit merr;
   always @(posedge clk) begin
      bit cl, sl;
      if (!rst_n) begin
         mcc <= 0; mcs <= 0; mac <= 1; mas <= 1; mpc <= 1; mps <= 1; merr <= 0;
      end else begin
         cl = (mcc == mac - 1);
         sl = (mcs == mas - 1);
         mcc <= cl ? 0 : mcc + 1;
         mcs <= sl ? 0 : mcs + 1;
         if (cl && sl) begin
            mac <= mpc;
            mas <= mps;
         end
         if (wr_en) begin
            mpc <= 1 << wdata[11:10];
            if (wdata[9:6] == 4'd0) merr <= 1'b1;
            else mps <= int'(wdata[9:6]);
         end
      end
   end

   function automatic logic [15:0] mk(int core, int sys, int mult);
      return {4'b0, 2'(core), 4'(sys), 6'(mult)};
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle, then compare both enables with the reference
   task automatic step(string req);
      @(negedge clk);
      check(core_en == (mcc == 0), {req, " core_en"}, core_en, mcc == 0);
      check(sys_en == (mcs == 0), {req, " sys_en"}, sys_en, mcs == 0);
   endtask

   task automatic run(int n, string req);
      for (int i = 0; i < n; i++) step(req);
   endtask

   task automatic write(logic [15:0] v, string req);
      wdata = v;
      wr_en = 1'b1;
      step(req);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      check(rdata == 16'h004A, "R1 rdata", rdata, 16'h004A);
      for (int i = 0; i < 5; i++) begin
         step("R1");
         check(core_en && sys_en, "R4 both high", {core_en, sys_en}, 2'b11);
      end
   endtask

   task automatic t_core_ratios();
      for (int c = 0; c < 4; c++) begin
         write(mk(c, 1, 0), "R2");
         check(rdata[11:10] == 2'(c), "R9 core readback", rdata[11:10], c);
         run(140, "R2");
      end
   endtask

   task automatic t_sys_ratios();
      write(mk(0, 1, 0), "R3");
      run(20, "R3");
      for (int s = 1; s < 16; s++) begin
         write(mk(0, s, 0), "R3");
         check(rdata[9:6] == 4'(s), "R9 sys readback", rdata[9:6], s);
         run(50, "R3");
      end
   endtask

   task automatic t_unit_high();
      write(mk(0, 1, 0), "R4");
      run(40, "R4");
      for (int i = 0; i < 20; i++) begin
         step("R4");
         check(core_en && sys_en, "R4 held high", {core_en, sys_en}, 2'b11);
      end
   endtask

   task automatic t_zero_code();
      write(mk(0, 5, 0), "R5");
      run(30, "R5");
      write(mk(1, 0, 0), "R5");
      check(rdata[9:6] == 4'd5, "R5 sys kept", rdata[9:6], 5);
      check(rdata[11:10] == 2'd1, "R5 core applied", rdata[11:10], 1);
      check(rdata[15] == 1'b1, "R5 error set", rdata[15], 1);
      run(60, "R5");
      write(mk(0, 3, 0), "R5");
      check(rdata[15] == 1'b1, "R5 error sticky", rdata[15], 1);
      run(30, "R5");
   endtask

   task automatic t_mult();
      write(mk(0, 2, 63), "R6");
      check(rdata[5:0] == 6'd10, "R6 multiplier", rdata[5:0], 10);
      run(10, "R6");
   endtask

   task automatic t_on_the_fly();
      write(mk(3, 7, 0), "R7");
      run(3, "R7");
      write(mk(2, 9, 0), "R7");
      run(5, "R7");
      write(mk(1, 13, 0), "R7");
      run(200, "R7");
   endtask

   task automatic t_align();
      write(mk(1, 6, 0), "R8");
      run(40, "R8");
      for (int i = 0; i < 60; i++) begin
         step("R8");
         if (sys_en) check(core_en, "R8 sys on core", core_en, 1);
      end
      write(mk(3, 4, 0), "R8");
      run(40, "R8");
      for (int i = 0; i < 60; i++) begin
         step("R8");
         if (core_en) check(sys_en, "R8 core on sys", sys_en, 1);
      end
   endtask

   task automatic t_reset_clears();
      do_reset();
      check(rdata == 16'h004A, "R1 error cleared by reset", rdata, 16'h004A);
      run(5, "R1");
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_core_ratios();
      t_sys_ratios();
      t_unit_high();
      t_zero_code();
      t_mult();
      t_on_the_fly();
      t_align();
      t_reset_clears();
      finish_run();
   end
endmodule